// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block derives a card clock from a base clock. Two static select levels choose whether the card sees the base clock unchanged or divided by two, four or eight. Each divided output has a 50 % duty cycle, and its high and low phases are always whole numbers of base cycles.

When the select levels move, the block does not follow them at once. A new select code must stay unchanged for a settling window of base cycles. Any change during the window, including a passing intermediate code while the two levels move one after the other, starts the window again.

Once the window has elapsed, the new ratio is loaded only at a boundary of the output. That is the last base cycle of a low phase, or any cycle when the output is running at full rate. Because of this, no phase is ever cut short. A synchronous active-low reset holds the output low and loads the ratio straight from the select levels.

Top module: `card_clk_div`

## Requirements
- R1: The select code {rate_a_i, rate_b_i} maps as follows: 2'b00 gives divide by 8, 2'b01 gives divide by 4, 2'b11 gives divide by 2, and 2'b10 gives the undivided base clock.
- R2: In a divided ratio N, card_clk_o has a period of N base cycles. It is high for N/2 cycles and low for N/2 cycles, and it changes only on base clock rising edges.
- R3: In the undivided ratio, card_clk_o follows clk_i.
- R4: A new select code takes effect no earlier than 10 rising edges after the edge that first sampled it. The settling length is SETTLE_CYCLES.
- R5: Each sampled change of the select code restarts the settling count. An intermediate code held for less than the window never takes effect.
- R6: A ratio change is applied only at the end of a low phase, or at any edge while running at full rate. Every high or low phase therefore lasts 1, 2, 4 or 8 half base periods.
- R7: While rst_ni is low, card_clk_o is low. After reset the ratio given by the select pins applies without any settling delay: the first rising edge after release starts a high phase.
- R8: A select code that returns to the active ratio before the window ends causes no change to the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| rate_a_i | input | 1 | First select level (code bit 1) |
| rate_b_i | input | 1 | Second select level (code bit 0) |
| card_clk_o | output | 1 | Divided card clock |

## Verification
The bench applies each of the four codes in turn and holds it long enough to observe steady periods. This separates the decoding and the duty cycle of each ratio. It then moves the select levels one at a time, so that an intermediate code exists for a few cycles. This distinguishes a block that restarts its settling count from one that commits the passing code. A short excursion away from the active code and back shows that an abandoned request leaves the output alone. Switches between divide by 8 and full rate at several offsets within the output period show whether the switch waits for a low-phase boundary. Those runs are also checked for phase widths that are neither the old nor the new one.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    // Largest division ratio and the widths derived from it.
    localparam int unsigned MAX_DIV = 8;
    localparam int unsigned PH_W    = $clog2(MAX_DIV / 2);
    localparam int unsigned HALF_W  = PH_W + 1;

    typedef logic [1:0] rate_code_t;

    localparam rate_code_t CODE_DIV8 = 2'b00;
    localparam rate_code_t CODE_DIV4 = 2'b01;
    localparam rate_code_t CODE_DIV2 = 2'b11;
    localparam rate_code_t CODE_FULL = 2'b10;

    // True when the code selects the undivided base clock.
    function automatic logic is_full(rate_code_t c);
        return c == CODE_FULL;
    endfunction

    // Half period in base cycles. Full rate reports 1, which the divider
    // uses only for its reset-time phase position.
    function automatic logic [HALF_W-1:0] half_of(rate_code_t c);
        logic [HALF_W-1:0] h;
        unique case (c)
            CODE_DIV8: h = HALF_W'(4);
            CODE_DIV4: h = HALF_W'(2);
            CODE_DIV2: h = HALF_W'(1);
            default:   h = HALF_W'(1);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/ccd_settle.sv
module ccd_settle
    import ccd_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 10
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  rate_code_t code_i,
    input  logic       boundary_i,
    output logic       commit_o,
    output rate_code_t req_code_o,
    output rate_code_t act_code_o
);

    localparam int unsigned STL_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [STL_W-1:0] STL_DONE = STL_W'(SETTLE_CYCLES);

    typedef struct packed {
        rate_code_t       req;
        rate_code_t       act;
        logic [STL_W-1:0] stl;
    } settle_t;

    settle_t s_d, s_q;
    logic    commit_d;

    always_comb begin
        s_d      = s_q;
        commit_d = 1'b0;
        if (code_i != s_q.req) begin
            // Any new code, even an intermediate one, restarts the window.
            s_d.req = code_i;
            s_d.stl = STL_W'(1);
        end else if (s_q.stl == STL_DONE) begin
            if (s_q.req == s_q.act) begin
                s_d.stl = '0;
            end else if (boundary_i) begin
                commit_d = 1'b1;
                s_d.act  = s_q.req;
                s_d.stl  = '0;
            end
        end else if (s_q.stl != '0) begin
            s_d.stl = s_q.stl + STL_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.req <= code_i;
            s_q.act <= code_i;
            s_q.stl <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign commit_o   = commit_d;
    assign req_code_o = s_q.req;
    assign act_code_o = s_q.act;

    AST_STL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.stl <= STL_DONE); // R4

    AST_COMMIT_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.act != $past(s_q.act)) |-> ($past(s_q.stl) == STL_DONE)); // R4

    AST_COMMIT_MATCHES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.act != $past(s_q.act)) |-> ($past(code_i) == s_q.act)); // R5

endmodule

// File: rtl/ccd_divider.sv
module ccd_divider
    import ccd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       commit_i,
    input  rate_code_t next_code_i,
    input  rate_code_t act_code_i,
    input  rate_code_t rst_code_i,
    output logic       full_o,
    output logic       level_o,
    output logic       boundary_o
);

    typedef struct packed {
        logic            full;
        logic            lvl;
        logic [PH_W-1:0] ph;
    } div_t;

    div_t              s_d, s_q;
    logic [HALF_W-1:0] half_c;
    logic              term_c;

    assign half_c = half_of(act_code_i);
    assign term_c = ({1'b0, s_q.ph} == (half_c - HALF_W'(1)));

    always_comb begin
        s_d = s_q;
        if (commit_i) begin
            // The new ratio begins with a fresh high phase.
            s_d.ph = '0;
            if (is_full(next_code_i)) begin
                s_d.full = 1'b1;
                s_d.lvl  = 1'b0;
            end else begin
                s_d.full = 1'b0;
                s_d.lvl  = 1'b1;
            end
        end else if (!s_q.full) begin
            if (term_c) begin
                s_d.ph = '0;
                if (s_q.lvl) begin
                    s_d.lvl = 1'b0;
                end else if (is_full(act_code_i)) begin
                    s_d.full = 1'b1;
                end else begin
                    s_d.lvl = 1'b1;
                end
            end else begin
                s_d.ph = s_q.ph + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.full <= 1'b0;
            s_q.lvl  <= 1'b0;
            s_q.ph   <= PH_W'(half_of(rst_code_i) - HALF_W'(1));
        end else begin
            s_q <= s_d;
        end
    end

    assign full_o     = s_q.full;
    assign level_o    = s_q.lvl;
    assign boundary_o = s_q.full | (~s_q.lvl & term_c);

    AST_FULL_KEEPS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.full |-> !s_q.lvl); // R3

    AST_PH_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, s_q.ph} < half_c); // R2

    AST_PHASE_WHOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.full && !$past(s_q.full) && (s_q.lvl != $past(s_q.lvl)))
        |-> ({1'b0, $past(s_q.ph)} == ($past(half_c) - HALF_W'(1)))); // R6

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import ccd_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rate_a_i,
    input  logic rate_b_i,
    output logic card_clk_o
);

    rate_code_t code_c;
    rate_code_t req_code;
    rate_code_t act_code;
    logic       commit;
    logic       boundary;
    logic       full_mode;
    logic       div_level;

    assign code_c = {rate_a_i, rate_b_i};

    ccd_settle #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) i_settle (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .code_i     (code_c),
        .boundary_i (boundary),
        .commit_o   (commit),
        .req_code_o (req_code),
        .act_code_o (act_code)
    );

    ccd_divider i_divider (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .commit_i    (commit),
        .next_code_i (req_code),
        .act_code_i  (act_code),
        .rst_code_i  (code_c),
        .full_o      (full_mode),
        .level_o     (div_level),
        .boundary_o  (boundary)
    );

    // The mode changes only at a rising edge, while the divided level is
    // low or about to start a high phase, so the two sources meet cleanly.
    assign card_clk_o = full_mode ? clk_i : div_level;

    AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_code != $past(act_code)) |-> $past(boundary)); // R6

endmodule

// File: tb/test_card_clk_div.sv
module test_card_clk_div;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 1'b0;
    logic b = 1'b0;
    logic card;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R7";

    // Reference model state
    int m_req, m_act, m_stl, m_full, m_level, m_left;
    int run_len = 0;
    int last_val = -1;
    bit started = 1'b0;

    always #10 clk = ~clk;

    card_clk_div i_card_clk_div (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .rate_a_i   (a),
        .rate_b_i   (b),
        .card_clk_o (card)
    );

    function automatic int half_cycles(int code);
        case (code)
            0: return 4;
            1: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic check(int act, int exp, string req, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic watch_width(int v);
        if (!rst_n) begin
            started  = 1'b0;
            run_len  = 0;
            last_val = v;
            return;
        end
        if (v == last_val) begin
            run_len++;
        end else begin
            if (started) begin
                // R6: every phase is a whole width of some ratio
                check(int'(run_len == 1 || run_len == 2 || run_len == 4 || run_len == 8),
                      1, "R6", "phase width legal");
            end
            started  = 1'b1;
            run_len  = 1;
            last_val = v;
        end
    endtask

    task automatic model_step();
        int code;
        bit commit;
        bit boundary;
        code = {a, b};
        if (!rst_n) begin
            m_req = code; m_act = code; m_stl = 0;
            m_full = 0; m_level = 0; m_left = 1;
            return;
        end
        boundary = (m_full != 0) || (m_level == 0 && m_left == 1);
        commit = 1'b0;
        if (code != m_req) begin
            m_req = code;
            m_stl = 1;
        end else if (m_stl == 10) begin
            if (m_req == m_act) m_stl = 0;
            else if (boundary) begin
                commit = 1'b1;
                m_stl = 0;
            end
        end else if (m_stl > 0) begin
            m_stl++;
        end
        if (commit) begin
            m_act = m_req;
            m_left = half_cycles(m_act);
            if (m_act == 2) begin
                m_full = 1; m_level = 0;
            end else begin
                m_full = 0; m_level = 1;
            end
        end else if (m_full == 0) begin
            if (m_left == 1) begin
                m_left = half_cycles(m_act);
                if (m_level != 0) m_level = 0;
                else if (m_act == 2) m_full = 1;
                else m_level = 1;
            end else begin
                m_left--;
            end
        end
    endtask

    // Model update at each rising edge, comparison half a phase later.
    always begin
        @(posedge clk);
        model_step();
        #5;
        if (!done) begin
            check(int'(card), (m_full != 0) ? 1 : m_level, cur_req, "high-half sample");
            watch_width(int'(card));
        end
        @(negedge clk);
        #5;
        if (!done) begin
            check(int'(card), (m_full != 0) ? 0 : m_level, cur_req, "low-half sample");
            watch_width(int'(card));
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_code(bit na, bit nb);
        @(negedge clk);
        a = na;
        b = nb;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R7: reset holds output low, divide by 8 from pins
        cur_req = "R7";
        rst_n = 1'b0; a = 1'b0; b = 1'b0;
        cycles(4);
        #5 check(int'(card), 0, "R7", "low during reset");
        @(negedge clk) rst_n = 1'b1;
        cur_req = "R2";
        cycles(40);
        // R4: divide by 4 after settling
        cur_req = "R4";
        set_code(1'b0, 1'b1);
        cycles(30);
        cur_req = "R2";
        set_code(1'b1, 1'b1);
        cycles(30);
        // R3: full rate
        cur_req = "R3";
        set_code(1'b1, 1'b0);
        cycles(30);
        // R5: intermediate code 2'b11 held briefly, then 2'b01
        cur_req = "R5";
        set_code(1'b1, 1'b1);
        cycles(5);
        set_code(1'b0, 1'b1);
        cycles(30);
        // R8: excursion to 2'b00 and back to the active code
        cur_req = "R8";
        set_code(1'b0, 1'b0);
        cycles(4);
        set_code(1'b0, 1'b1);
        cycles(40);
        // R6: switches between divide by 8 and full rate at varied offsets
        cur_req = "R6";
        set_code(1'b0, 1'b0);
        cycles(41);
        set_code(1'b1, 1'b0);
        cycles(13);
        set_code(1'b0, 1'b0);
        cycles(17);
        set_code(1'b1, 1'b0);
        cycles(25);
        // R1: reset with full-rate code, then with divide by 2
        cur_req = "R1";
        @(negedge clk) rst_n = 1'b0;
        cycles(3);
        @(negedge clk) rst_n = 1'b1;
        cycles(20);
        @(negedge clk) begin rst_n = 1'b0; a = 1'b1; b = 1'b1; end
        cycles(3);
        @(negedge clk) rst_n = 1'b1;
        cycles(20);
        finish_run();
    end

endmodule